// File: doc/BRIEF.md
# Indirect-Access Switch Address Table

This block holds the address-lookup table of a small Ethernet switch, together with the few configuration registers that go with it, behind a plain 32-bit register bus. Each table entry is 68 bits wide and cannot be reached in one bus word. The host therefore works through a three-word staging area. To change an entry, it fills the staging words and then writes the table-control register with the commit flag set. To read an entry, it writes the table-control register with the commit flag clear; the selected entry is copied into the staging words, where the host can read it.

Besides the table, the block keeps a global control register, one control register per switch port and a read-only identification word. The global control register has an enable bit, a one-shot ageing trigger and a table-wipe request. A wipe sets every entry to the free type, one entry per clock. Lookup, forwarding and rate limiting belong to other blocks. This block only stores and exports their configuration bits.

Top module: `swtab_top`

## Requirements
- R1: After reset, the identification word at offset 0x00 reads {ID_CODE[15:0], REV_MAJOR[7:0], REV_MINOR[7:0]}, with the major revision in bits 15:8 and the minor revision in bits 7:0. Writes to it have no effect.
- R2: The staging words map onto the 68-bit entry as follows: offset 0x3C holds entry bits 31:0, offset 0x38 holds entry bits 63:32, and offset 0x34 holds entry bits 67:64 in its bits 3:0. Bits 31:4 of offset 0x34 are not stored and read 0.
- R3: A write to the table-control register (0x20) with bit 31 set copies the staged 68-bit value into the entry whose number is in bits 9:0 of the written data.
- R4: A write to 0x20 with bit 31 clear loads the selected entry into the staging words. Offset 0x20 reads back bits 9:0 of the last index written, and its bit 31 reads 0.
- R5: In the global control register (0x08), bit 31 is the table enable, drives `tab_enable`, and is read back. Bits 7:0 are plain stored bits. Writing 1 to bit 29 raises `age_strobe` for exactly the next clock cycle, and bit 29 reads 0.
- R6: Writing 1 to bit 30 of 0x08 starts a wipe that writes all-zero entries (type field, bits 61:60, equal to 0 = free) to entries 0 through ENTRIES-1, one per clock, in increasing order. Bit 30 reads 1 while the wipe runs and 0 once it is done.
- R7: Table-control writes made while a wipe runs do not commit and do not load; the staging words keep their contents.
- R8: An index at or above ENTRIES (default 64) is ignored by a commit and makes no entry change, including the entry that shares its low bits. A load of such an index puts zeros in all three staging words.
- R9: The control register of port p sits at 0x40 + 4*p for p < NPORTS. It stores bits 1:0 (port state: 0 disabled, 1 blocking, 2 learning, 3 forwarding), bits 4:2 and bits 31:16; other bits read 0. Bits 1:0 of port p drive `port_state[2p+1:2p]`.
- R10: Read data appears on `bus_rdata` in the cycle after the read request and holds until the next read. Addresses with no register, including port slots at or beyond NPORTS, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| tab_enable | output | 1 | Stored global enable bit |
| age_strobe | output | 1 | One-cycle ageing trigger pulse |
| port_state | output | 2*NPORTS | State field of every port control register |

## Verification
The checker holds on every cycle the properties of the wipe sequencer. The pointer starts at zero and steps by one each clock, the wipe stops after the last entry, and no commit or load gets through while the wipe runs. It also checks that an out-of-range commit never fires, that the ageing pulse only follows a request, and that the clear bit reads back as busy. The entry contents are another matter. Only the bench's scenarios show that they survive the reversed word order, that a wipe actually leaves zeros, that a high index does not alias onto a low one, and that the stored register fields read back.

// File: rtl/swtab_pkg.sv
`timescale 1ns/1ps
package swtab_pkg;

  localparam int ENT_W       = 68;
  localparam int WORD_W      = 32;
  localparam int IDX_FIELD_W = 10;
  localparam int N_WORDS     = 3;

  // register offsets (byte addresses)
  localparam logic [7:0] OFS_IDVER = 8'h00;
  localparam logic [7:0] OFS_GCTL  = 8'h08;
  localparam logic [7:0] OFS_TCTL  = 8'h20;
  localparam logic [7:0] OFS_W0    = 8'h34;
  localparam logic [7:0] OFS_W1    = 8'h38;
  localparam logic [7:0] OFS_W2    = 8'h3C;
  localparam logic [7:0] OFS_PORT0 = 8'h40;

  // global control bit positions
  localparam int GC_ENABLE = 31;
  localparam int GC_WIPE   = 30;
  localparam int GC_AGE    = 29;
  // table control commit flag
  localparam int TC_COMMIT = 31;

  localparam logic [WORD_W-1:0] GC_KEEP_MASK = 32'h8000_00FF;
  localparam logic [WORD_W-1:0] PC_KEEP_MASK = 32'hFFFF_001F;

  typedef logic [ENT_W-1:0] entry_t;

  // byte address of the control register of port p
  function automatic logic [7:0] port_ofs(int p);
    return 8'(32'(OFS_PORT0) + 4 * p);
  endfunction

  // bus view of one staging word; word 0 carries the top nibble
  function automatic logic [WORD_W-1:0] word_of(entry_t e, logic [1:0] w);
    logic [WORD_W-1:0] r;
    case (w)
      2'd0:    r = {28'd0, e[67:64]};
      2'd1:    r = e[63:32];
      default: r = e[31:0];
    endcase
    return r;
  endfunction

  // replace one staging word inside an entry image
  function automatic entry_t merge_word(entry_t e, logic [1:0] w,
                                        logic [WORD_W-1:0] d);
    entry_t r;
    r = e;
    case (w)
      2'd0:    r[67:64] = d[3:0];
      2'd1:    r[63:32] = d;
      default: r[31:0]  = d;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/swtab_wipe.sv
`timescale 1ns/1ps
module swtab_wipe #(
  parameter int ENTRIES = 64,
  localparam int PTR_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [PTR_W-1:0] ptr,
  output logic             last
);

  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(ENTRIES - 1);

  assign last = busy && (ptr == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ptr  <= '0;
    end else if (busy) begin
      if (last) begin
        busy <= 1'b0;
        ptr  <= '0;
      end else begin
        ptr <= ptr + 1'b1;
      end
    end else if (start) begin
      busy <= 1'b1;
      ptr  <= '0;
    end
  end

endmodule

// File: rtl/swtab_store.sv
`timescale 1ns/1ps
module swtab_store
  import swtab_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_WORDS-1:0]     stage_we,
  input  logic [WORD_W-1:0]      stage_data,
  input  logic                   tc_fire,
  input  logic                   tc_commit,
  input  logic [IDX_FIELD_W-1:0] tc_idx,
  input  logic                   wipe_busy,
  input  logic [IDX_W-1:0]       wipe_ptr,
  output entry_t                 staged,
  output logic                   commit_fire,
  output logic                   load_fire,
  output logic                   idx_ok
);

  entry_t           mem [ENTRIES];
  entry_t           staged_nx;
  logic [IDX_W-1:0] tab_addr;

  assign idx_ok      = 32'(tc_idx) < ENTRIES;
  assign tab_addr    = tc_idx[IDX_W-1:0];
  assign commit_fire = tc_fire && tc_commit && !wipe_busy && idx_ok;
  assign load_fire   = tc_fire && !tc_commit && !wipe_busy;

  // table array: wipe has the port while it runs, else commits
  always_ff @(posedge clk) begin
    if (wipe_busy)
      mem[wipe_ptr] <= '0;
    else if (commit_fire)
      mem[tab_addr] <= staged;
  end

  always_comb begin
    staged_nx = staged;
    for (int w = 0; w < N_WORDS; w++) begin
      if (stage_we[w])
        staged_nx = merge_word(staged_nx, 2'(w), stage_data);
    end
    if (load_fire)
      staged_nx = idx_ok ? mem[tab_addr] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      staged <= '0;
    else
      staged <= staged_nx;
  end

endmodule

// File: rtl/swtab_ctrl.sv
`timescale 1ns/1ps
module swtab_ctrl
  import swtab_pkg::*;
#(
  parameter int NPORTS = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          gc_we,
  input  logic [NPORTS-1:0]             pc_we,
  input  logic [WORD_W-1:0]             wdata,
  input  logic                          wipe_busy,
  output logic [WORD_W-1:0]             gctl_q,
  output logic                          age_strobe,
  output logic                          wipe_start,
  output logic [NPORTS-1:0][WORD_W-1:0] pctl_q
);

  assign wipe_start = gc_we && wdata[GC_WIPE] && !wipe_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gctl_q     <= '0;
      age_strobe <= 1'b0;
    end else begin
      age_strobe <= gc_we && wdata[GC_AGE];
      if (gc_we)
        gctl_q <= wdata & GC_KEEP_MASK;
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pctl_q[p] <= '0;
      else if (pc_we[p])
        pctl_q[p] <= wdata & PC_KEEP_MASK;
    end
  end

endmodule

// File: rtl/swtab_top.sv
`timescale 1ns/1ps
module swtab_top
  import swtab_pkg::*;
#(
  parameter int          ENTRIES   = 64,
  parameter int          NPORTS    = 3,
  parameter int          ADDR_W    = 8,
  parameter logic [15:0] ID_CODE   = 16'h5A17,
  parameter logic [7:0]  REV_MAJOR = 8'h01,
  parameter logic [7:0]  REV_MINOR = 8'h04,
  localparam int         PTR_W     = $clog2(ENTRIES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [WORD_W-1:0]     bus_wdata,
  output logic [WORD_W-1:0]     bus_rdata,
  output logic                  tab_enable,
  output logic                  age_strobe,
  output logic [2*NPORTS-1:0]   port_state
);

  // named internal events (also observed by the checker)
  logic                          wr_fire, rd_fire;
  logic                          gc_fire, gc_rd, tc_fire;
  logic [N_WORDS-1:0]            stage_we;
  logic [NPORTS-1:0]             pc_we;
  logic                          wipe_busy, wipe_last, wipe_start;
  logic [PTR_W-1:0]              wipe_ptr;
  logic                          commit_fire, load_fire, idx_ok;
  entry_t                        staged;
  logic [WORD_W-1:0]             gctl_q;
  logic [NPORTS-1:0][WORD_W-1:0] pctl_q;
  logic [IDX_FIELD_W-1:0]        tc_idx_q;
  logic [WORD_W-1:0]             rd_next;

  assign wr_fire = bus_sel && bus_we;
  assign rd_fire = bus_sel && !bus_we;
  assign gc_fire = wr_fire && (bus_addr == ADDR_W'(OFS_GCTL));
  assign gc_rd   = rd_fire && (bus_addr == ADDR_W'(OFS_GCTL));
  assign tc_fire = wr_fire && (bus_addr == ADDR_W'(OFS_TCTL));
  assign stage_we[0] = wr_fire && (bus_addr == ADDR_W'(OFS_W0));
  assign stage_we[1] = wr_fire && (bus_addr == ADDR_W'(OFS_W1));
  assign stage_we[2] = wr_fire && (bus_addr == ADDR_W'(OFS_W2));

  for (genvar p = 0; p < NPORTS; p++) begin : g_pdec
    assign pc_we[p] = wr_fire && (bus_addr == ADDR_W'(port_ofs(p)));
    assign port_state[2*p +: 2] = pctl_q[p][1:0];
  end

  swtab_wipe #(.ENTRIES(ENTRIES)) u_wipe (
    .clk   (clk),
    .rst_n (rst_n),
    .start (wipe_start),
    .busy  (wipe_busy),
    .ptr   (wipe_ptr),
    .last  (wipe_last)
  );

  swtab_store #(.ENTRIES(ENTRIES)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .stage_we    (stage_we),
    .stage_data  (bus_wdata),
    .tc_fire     (tc_fire),
    .tc_commit   (bus_wdata[TC_COMMIT]),
    .tc_idx      (bus_wdata[IDX_FIELD_W-1:0]),
    .wipe_busy   (wipe_busy),
    .wipe_ptr    (wipe_ptr),
    .staged      (staged),
    .commit_fire (commit_fire),
    .load_fire   (load_fire),
    .idx_ok      (idx_ok)
  );

  swtab_ctrl #(.NPORTS(NPORTS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .gc_we      (gc_fire),
    .pc_we      (pc_we),
    .wdata      (bus_wdata),
    .wipe_busy  (wipe_busy),
    .gctl_q     (gctl_q),
    .age_strobe (age_strobe),
    .wipe_start (wipe_start),
    .pctl_q     (pctl_q)
  );

  assign tab_enable = gctl_q[GC_ENABLE];

  // last index written to table control
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tc_idx_q <= '0;
    else if (tc_fire)
      tc_idx_q <= bus_wdata[IDX_FIELD_W-1:0];
  end

  // read multiplexer
  always_comb begin
    rd_next = '0;
    if (bus_addr == ADDR_W'(OFS_IDVER))
      rd_next = {ID_CODE, REV_MAJOR, REV_MINOR};
    else if (bus_addr == ADDR_W'(OFS_GCTL)) begin
      rd_next = gctl_q;
      rd_next[GC_WIPE] = wipe_busy;
    end else if (bus_addr == ADDR_W'(OFS_TCTL))
      rd_next = WORD_W'(tc_idx_q);
    else if (bus_addr == ADDR_W'(OFS_W0))
      rd_next = word_of(staged, 2'd0);
    else if (bus_addr == ADDR_W'(OFS_W1))
      rd_next = word_of(staged, 2'd1);
    else if (bus_addr == ADDR_W'(OFS_W2))
      rd_next = word_of(staged, 2'd2);
    for (int p = 0; p < NPORTS; p++) begin
      if (bus_addr == ADDR_W'(port_ofs(p)))
        rd_next = pctl_q[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bus_rdata <= '0;
    else if (rd_fire)
      bus_rdata <= rd_next;
  end

endmodule

// File: rtl/swtab_chk.sv
`timescale 1ns/1ps
module swtab_chk #(
  parameter int ENTRIES = 64,
  localparam int PTR_W  = $clog2(ENTRIES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tc_fire,
  input logic             gc_fire,
  input logic             gc_rd,
  input logic             cmd_commit,
  input logic             cmd_age,
  input logic [9:0]       cmd_idx,
  input logic             rd_clear_bit,
  input logic             age_strobe,
  input logic             wipe_busy,
  input logic [PTR_W-1:0] wipe_ptr,
  input logic             wipe_last,
  input logic             commit_fire,
  input logic             load_fire
);

  AST_WIPE_BLOCKS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_busy |-> (!commit_fire && !load_fire)); // R7

  AST_WIPE_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wipe_busy) |-> (wipe_ptr == '0)); // R6

  AST_WIPE_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wipe_busy && !wipe_last) |=>
      (wipe_busy && (wipe_ptr == PTR_W'($past(wipe_ptr) + 1'b1)))); // R6

  AST_WIPE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_last |=> !wipe_busy); // R6

  AST_CLEAR_READS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (gc_rd && wipe_busy) |=> rd_clear_bit); // R6

  AST_HIGH_INDEX_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_fire && cmd_commit && (32'(cmd_idx) >= ENTRIES)) |-> !commit_fire); // R8

  AST_AGE_ONLY_ON_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    age_strobe |-> $past(gc_fire && cmd_age)); // R5

endmodule

bind swtab_top swtab_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tc_fire      (tc_fire),
  .gc_fire      (gc_fire),
  .gc_rd        (gc_rd),
  .cmd_commit   (bus_wdata[31]),
  .cmd_age      (bus_wdata[29]),
  .cmd_idx      (bus_wdata[9:0]),
  .rd_clear_bit (bus_rdata[30]),
  .age_strobe   (age_strobe),
  .wipe_busy    (wipe_busy),
  .wipe_ptr     (wipe_ptr),
  .wipe_last    (wipe_last),
  .commit_fire  (commit_fire),
  .load_fire    (load_fire)
);

// File: tb/sim_swtab_top.sv
`timescale 1ns/1ps
module sim_swtab_top;

  localparam int NP = 3;
  localparam int NE = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_we = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          tab_enable;
  logic          age_strobe;
  logic [2*NP-1:0] port_state;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  swtab_top #(.ENTRIES(NE), .NPORTS(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tab_enable(tab_enable), .age_strobe(age_strobe), .port_state(port_state)
  );

  function automatic logic [67:0] mk(logic [5:0] hi, logic [1:0] ty,
                                     logic [11:0] vid, logic [47:0] mac);
    return {hi, ty, vid, mac};
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  // stage an entry; junk in the unused upper bits of the top word
  task automatic stage(logic [67:0] e);
    wr(8'h34, {28'hFFFFFFF, e[67:64]});
    wr(8'h38, e[63:32]);
    wr(8'h3C, e[31:0]);
  endtask

  task automatic expect_staged(string req, logic [67:0] e);
    logic [31:0] v;
    rd(8'h34, v); chk(req, v, {28'd0, e[67:64]});
    rd(8'h38, v); chk(req, v, e[63:32]);
    rd(8'h3C, v); chk(req, v, e[31:0]);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h00, v); chk("R1 idver", v, 32'h5A17_0104);
    @(negedge clk);
    chk("R10 rdata held", bus_rdata, 32'h5A17_0104);
    rd(8'h08, v); chk("R5 gctl reset", v, 32'h0);
    chk("R5 enable reset", {31'd0, tab_enable}, 32'd0);
    chk("R9 port_state reset", {26'd0, port_state}, 32'd0);
    rd(8'h10, v); chk("R10 unmapped", v, 32'h0);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); chk("R1 idver write ignored", v, 32'h5A17_0104);
  endtask

  task automatic t_wipe;
    logic [31:0] v;
    logic [67:0] pat;
    pat = mk(6'h15, 2'b11, 12'hABC, 48'hDEAD_BEEF_0102);
    stage(pat);
    wr(8'h08, 32'h4000_0000);
    rd(8'h08, v); chk("R6 clear busy", v & 32'h4000_0000, 32'h4000_0000);
    wr(8'h20, 32'd3);           // load during wipe: must be dropped
    expect_staged("R7 load during wipe", pat);
    repeat (NE + 8) @(negedge clk);
    rd(8'h08, v); chk("R6 clear done", v & 32'h4000_0000, 32'h0);
    wr(8'h20, 32'd0);  expect_staged("R6 entry0 free", 68'd0);
    wr(8'h20, 32'd63); expect_staged("R6 entry63 free", 68'd0);
  endtask

  task automatic t_commit_load;
    logic [31:0] v;
    logic [67:0] e1, e2;
    e1 = mk(6'h2D, 2'b01, 12'h123, 48'h0011_2233_4455);
    e2 = mk(6'h0A, 2'b10, 12'hFED, 48'h6677_8899_AABB);
    stage(e1); wr(8'h20, 32'h8000_0005);
    stage(e2); wr(8'h20, 32'h8000_003F);
    stage(68'hF_FFFF_FFFF_FFFF_FFFF);
    wr(8'h20, 32'd5);
    expect_staged("R2 R3 R4 entry5", e1);
    rd(8'h20, v); chk("R4 index readback", v, 32'd5);
    wr(8'h20, 32'd63);
    expect_staged("R3 R4 entry63", e2);
    // entry 5 untouched by the commit to 63
    wr(8'h20, 32'd5);
    expect_staged("R3 entry5 kept", e1);
  endtask

  task automatic t_range;
    logic [67:0] e3;
    e3 = mk(6'h33, 2'b01, 12'h777, 48'h1234_5678_9ABC);
    stage(e3); wr(8'h20, 32'h8000_0040);  // index 64 = ENTRIES
    wr(8'h20, 32'd0);
    expect_staged("R8 no alias to entry0", 68'd0);
    stage(e3);
    wr(8'h20, 32'd64);
    expect_staged("R8 high load zeros", 68'd0);
  endtask

  task automatic t_global;
    logic [31:0] v;
    wr(8'h08, 32'hA000_00F5);
    chk("R5 age pulse high", {31'd0, age_strobe}, 32'd1);
    @(negedge clk);
    chk("R5 age pulse low", {31'd0, age_strobe}, 32'd0);
    rd(8'h08, v); chk("R5 gctl readback", v, 32'h8000_00F5);
    chk("R5 enable out", {31'd0, tab_enable}, 32'd1);
  endtask

  task automatic t_ports;
    logic [31:0] v;
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h44, 32'h0000_0002);
    wr(8'h48, 32'h1234_5671);
    rd(8'h40, v); chk("R9 port0 mask", v, 32'hFFFF_001F);
    rd(8'h48, v); chk("R9 port2", v, 32'h1234_0011);
    chk("R9 port_state", {26'd0, port_state}, {26'd0, 6'b01_10_11});
    wr(8'h4C, 32'hFFFF_FFFF);
    rd(8'h4C, v); chk("R9 R10 no port3", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wipe();
    t_commit_load();
    t_range();
    t_global();
    t_ports();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule